// File: doc/BRIEF.md
# Banked Write-One-to-Clear Fault Status Register

This block holds a 32-bit fault status word as two copies, one for each security state. Hardware fault logic sets bits through one 32-bit set strobe per security state. Software reads and clears the word through a simple memory-mapped request port. The word occupies a four-byte window. Any of its four byte addresses can be the target of a byte, halfword or word access, and the two low address bits pick the starting byte lane.

A secure attribute on each request picks the copy that the request reads or clears. Bits [15:8] form one field that both states share. That field is stored only in the non-secure copy, so a secure read sees it merged into the secure view, and a secure clear reaches it as well. Clearing is done by writing ones. Lanes that an access does not cover are never touched. Read data comes back right-justified one cycle after the request, and the port never stalls.

Top module: `fault_status_bank`

## Requirements
- R1: A request hits the register when its address lies in BASE_ADDR to BASE_ADDR+3 (default 12'hD28 to 12'hD2B). A read outside that window returns zero, and a write outside it changes neither copy.
- R2: `req_size` selects the access width: 0 means byte, 1 means halfword, 2 or 3 means word.
- R3: Each data bit written as 1 clears the addressed register bit. Each data bit written as 0 leaves it unchanged.
- R4: Write data is shifted left by 8 × (address − BASE_ADDR) bits before it is applied. Data bits above the access width are ignored, so lanes outside the access are never cleared.
- R5: `req_secure` = 1 selects the secure copy and 0 selects the non-secure copy. A set strobe for one state never changes the other state's bits outside [15:8].
- R6: Bits [15:8] are stored only in the non-secure copy. A secure read returns the secure copy ORed with non-secure bits [15:8]. A non-secure read returns the non-secure copy.
- R7: A secure write also clears any written ones that fall in bits [15:8] of the non-secure copy. A non-secure write never changes the secure copy.
- R8: Read data is the merged word shifted right by 8 × (address − BASE_ADDR) bits and masked to the access width, so bits above the access width are zero. A field that runs past bit 31 is truncated.
- R9: Set strobes OR into their copy every cycle. A set strobe of either state in bits [15:8] goes to the non-secure copy. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: After reset both copies read zero. `req_ready` is always 1. Every read request produces `rsp_valid` with its data on the next cycle, and only read requests produce a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write (clear), 0 = read |
| req_secure | input | 1 | Security state of the request, 1 = secure |
| req_addr | input | 12 | Byte address of the request |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-justified |
| set_sec | input | 32 | Fault set strobes for the secure state |
| set_ns | input | 32 | Fault set strobes for the non-secure state |

## Verification
A fault strobe and a software clear can land on the same bit in the same cycle. The bench provokes this by driving a non-secure set strobe on bit 9 in the same cycle as a non-secure byte write of ones to bits 9 and 8. A following byte read must show bit 9 still set and bit 8 cleared, which shows that the set won and that the clear still worked on the other bit. A secure set in the shared field, made in isolation, is then read back through the non-secure view to confirm that it was steered into the non-secure copy.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/fsr_lane_sel.sv
module fsr_lane_sel
  import fsr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    size,
  output logic [DW-1:0] bit_mask
);

  localparam int unsigned LANES = DW / LANE_W;

  logic [LANES-1:0] lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lane_en[g] = (g < 1);
        SZ_HALF: lane_en[g] = (g < 2);
        default: lane_en[g] = 1'b1;
      endcase
    end
    assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
  end

endmodule

// File: rtl/fsr_lane_align.sv
module fsr_lane_align
  import fsr_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned OFFW = 2
) (
  input  logic            hit,
  input  logic [1:0]      size,
  input  logic [OFFW-1:0] offset,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   clr_mask
);

  localparam int unsigned SHW = OFFW + 3;

  logic [DW-1:0]  width_mask;
  logic [DW-1:0]  kept;
  logic [SHW-1:0] shamt;

  fsr_lane_sel #(.DW(DW)) u_sel (
    .size     (size),
    .bit_mask (width_mask)
  );

  always_comb begin
    kept     = wdata & width_mask;
    shamt    = {offset, 3'b000};
    clr_mask = hit ? (kept << shamt) : '0;
  end

endmodule

// File: rtl/fsr_read_extract.sv
module fsr_read_extract
  import fsr_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned OFFW = 2
) (
  input  logic            hit,
  input  logic [1:0]      size,
  input  logic [OFFW-1:0] offset,
  input  logic [DW-1:0]   merged,
  output logic [DW-1:0]   field
);

  localparam int unsigned SHW = OFFW + 3;

  logic [DW-1:0]  width_mask;
  logic [SHW-1:0] shamt;

  fsr_lane_sel #(.DW(DW)) u_sel (
    .size     (size),
    .bit_mask (width_mask)
  );

  always_comb begin
    shamt = {offset, 3'b000};
    field = hit ? ((merged >> shamt) & width_mask) : '0;
  end

endmodule

// File: rtl/fsr_bank.sv
module fsr_bank #(
  parameter int unsigned    DW         = 32,
  parameter logic [DW-1:0]  STORE_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_q;
  logic [DW-1:0] q_d;
  logic          q_en;

  always_comb begin
    q_en = (|set_i) || (|clr_i);
    q_d  = ((q_q & ~clr_i) | set_i) & STORE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R9: a set strobe leaves its bits set, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i & STORE_MASK)) == $past(set_i & STORE_MASK)));

  // R3: a clear without a set leaves the bit at zero
  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R3: no strobe and no clear keep the copy unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fsr_pkg::*;
#(
  parameter int unsigned       DW        = 32,
  parameter int unsigned       AW        = 12,
  parameter logic [AW-1:0]     BASE_ADDR = 12'hD28,
  parameter int unsigned       SHARED_LO = 8,
  parameter int unsigned       SHARED_W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_secure,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic [DW-1:0] set_sec,
  input  logic [DW-1:0] set_ns
);

  localparam int unsigned   LANES       = DW / LANE_W;
  localparam int unsigned   OFFW        = $clog2(LANES);
  localparam logic [DW-1:0] SHARED_MASK = ((DW'(1) << SHARED_W) - DW'(1)) << SHARED_LO;

  logic            rst_i_n;
  logic            hit;
  logic [OFFW-1:0] offset;
  logic            rd_req;
  logic            wr_hit;
  logic [DW-1:0]   clr_mask;
  logic [DW-1:0]   sec_set;
  logic [DW-1:0]   ns_set;
  logic [DW-1:0]   sec_clr;
  logic [DW-1:0]   ns_clr;
  logic [DW-1:0]   sec_q;
  logic [DW-1:0]   ns_q;
  logic [DW-1:0]   merged;
  logic [DW-1:0]   field;
  logic            rsp_valid_q;
  logic            rsp_valid_d;
  logic [DW-1:0]   rsp_rdata_q;
  logic [DW-1:0]   rsp_rdata_d;
  logic            rdata_en;

  fsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // window decode
  always_comb begin
    hit    = (req_addr[AW-1:OFFW] == BASE_ADDR[AW-1:OFFW]);
    offset = req_addr[OFFW-1:0] - BASE_ADDR[OFFW-1:0];
    rd_req = req_valid && !req_write;
    wr_hit = req_valid && req_write && hit;
  end

  fsr_lane_align #(.DW(DW), .OFFW(OFFW)) u_align (
    .hit      (wr_hit),
    .size     (req_size),
    .offset   (offset),
    .wdata    (req_wdata),
    .clr_mask (clr_mask)
  );

  // bank steering of sets and clears
  always_comb begin
    sec_set = set_sec & ~SHARED_MASK;
    ns_set  = set_ns | (set_sec & SHARED_MASK);
    sec_clr = req_secure ? clr_mask : '0;
    ns_clr  = req_secure ? (clr_mask & SHARED_MASK) : clr_mask;
  end

  fsr_bank #(.DW(DW), .STORE_MASK(~SHARED_MASK)) u_sec_bank (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (sec_set),
    .clr_i (sec_clr),
    .q_o   (sec_q)
  );

  fsr_bank #(.DW(DW), .STORE_MASK('1)) u_ns_bank (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (ns_set),
    .clr_i (ns_clr),
    .q_o   (ns_q)
  );

  always_comb begin
    merged = req_secure ? (sec_q | (ns_q & SHARED_MASK)) : ns_q;
  end

  fsr_read_extract #(.DW(DW), .OFFW(OFFW)) u_extract (
    .hit    (hit),
    .size   (req_size),
    .offset (offset),
    .merged (merged),
    .field  (field)
  );

  // response next state
  always_comb begin
    rsp_valid_d = rd_req;
    rdata_en    = rd_req;
    rsp_rdata_d = field;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_rdata_q <= '0;
    end else if (rdata_en) begin
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign req_ready = 1'b1;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R10: each read is answered on the next cycle
  p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> rsp_valid);

  // R10: no response without a read
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_req |=> !rsp_valid);

  // R1: a read outside the window returns zero
  p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_req && !hit) |=> (rsp_rdata == '0));

  // R8: a byte read leaves the upper bits zero
  p_byte_width_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_req && req_size == SZ_BYTE) |=> (rsp_rdata[DW-1:LANE_W] == '0));

  // R7: a non-secure write leaves the secure copy alone
  p_ns_write_isolated_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_write && !req_secure && set_sec == '0) |=> $stable(sec_q));

  // R6: the secure copy never holds the shared field
  p_shared_in_ns_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(set_sec & SHARED_MASK) != '0 |-> ((ns_q & $past(set_sec & SHARED_MASK)) == $past(set_sec & SHARED_MASK)));

endmodule

// File: tb/fault_status_bank_tb_top.sv
`timescale 1ns/1ps
module fault_status_bank_tb_top;

  localparam logic [11:0] BASE = 12'hD28;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic        req_secure;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] set_sec;
  logic [31:0] set_ns;

  int n_tests;
  int n_fail;
  bit done;

  fault_status_bank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .set_sec    (set_sec),
    .set_ns     (set_ns)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {write, secure, offset[1:0], size[1:0], data[31:0], expected[31:0]}
  localparam int NV = 20;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 2'd1, 2'd0, 32'h0000_000F, 32'h0000_0000},
    {1'b0, 1'b0, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_F0FF},
    {1'b0, 1'b1, 2'd0, 2'd1, 32'h0000_0000, 32'h0000_F0FF},
    {1'b1, 1'b0, 2'd2, 2'd1, 32'h0000_00FF, 32'h0000_0000},
    {1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_F0FF},
    {1'b0, 1'b0, 2'd2, 2'd0, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 1'b1, 2'd0, 2'd2, 32'h0000_00F0, 32'h0000_0000},
    {1'b0, 1'b1, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_000F},
    {1'b0, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_00FF},
    {1'b1, 1'b0, 2'd3, 2'd0, 32'h0000_0080, 32'h0000_0000},
    {1'b0, 1'b0, 2'd0, 2'd2, 32'h0000_0000, 32'h7F00_F0FF},
    {1'b0, 1'b1, 2'd3, 2'd0, 32'h0000_0000, 32'h0000_00FF},
    {1'b1, 1'b1, 2'd2, 2'd1, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_F00F},
    {1'b1, 1'b0, 2'd1, 2'd0, 32'h0000_00F0, 32'h0000_0000},
    {1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_000F},
    {1'b0, 1'b0, 2'd2, 2'd1, 32'h0000_0000, 32'h0000_7F00},
    {1'b1, 1'b1, 2'd0, 2'd0, 32'hFFFF_FF01, 32'h0000_0000},
    {1'b0, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'hFFFF_000E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sec, input logic [11:0] addr,
                        input logic [1:0] sz, input logic [31:0] data,
                        output logic [31:0] rd, output logic vld);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_addr   = addr;
    req_size   = sz;
    req_wdata  = data;
    @(negedge clk);
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_wdata  = '0;
    rd  = rsp_rdata;
    vld = rsp_valid;
  endtask

  task automatic read_chk(input string req, input logic sec, input logic [11:0] addr,
                          input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] rd;
    logic        vld;
    access(1'b0, sec, addr, sz, 32'h0, rd, vld);
    check(req, vld ? rd : 32'hDEAD_BEEF, exp);
  endtask

  task automatic pulse_set(input logic [31:0] s, input logic [31:0] n);
    @(negedge clk);
    set_sec = s;
    set_ns  = n;
    @(negedge clk);
    set_sec = '0;
    set_ns  = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    logic        vld;
    n_tests = 0; n_fail = 0; done = 1'b0;
    req_valid = 0; req_write = 0; req_secure = 0; req_addr = BASE;
    req_size = 2'd2; req_wdata = '0; set_sec = '0; set_ns = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state and ready
    check("R10 ready", {31'h0, req_ready}, 32'h1);
    check("R10 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
    read_chk("R10 reset secure", 1'b1, BASE, 2'd2, 32'h0);
    read_chk("R10 reset non-secure", 1'b0, BASE, 2'd2, 32'h0);

    // fill both copies through the strobes
    pulse_set(32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R2 R3 R4 R5 R6 R7 R8: vector walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][69], VEC[i][68], BASE + 12'(VEC[i][67:66]), VEC[i][65:64],
             VEC[i][63:32], rd, vld);
      if (!VEC[i][69]) begin
        check($sformatf("R2/R3/R4/R6/R7/R8 vector %0d", i), vld ? rd : 32'hDEAD_BEEF, VEC[i][31:0]);
      end
    end

    // R1: every in-window address decodes, outside is ignored
    read_chk("R1 offset 1 byte", 1'b0, BASE + 12'd1, 2'd0, 32'h0000_0000);
    access(1'b1, 1'b0, BASE + 12'd4, 2'd2, 32'hFFFF_FFFF, rd, vld);
    access(1'b1, 1'b1, BASE - 12'd4, 2'd2, 32'hFFFF_FFFF, rd, vld);
    read_chk("R1 miss write ignored ns", 1'b0, BASE, 2'd2, 32'h7F00_00FF);
    read_chk("R1 miss write ignored sec", 1'b1, BASE, 2'd2, 32'hFFFF_000E);
    read_chk("R1 miss read zero", 1'b1, BASE + 12'd4, 2'd2, 32'h0);

    // R8: halfword at the last lane is truncated
    read_chk("R8 truncated halfword", 1'b0, BASE + 12'd3, 2'd1, 32'h0000_007F);

    // R9: shared-field set from the secure side lands in the non-secure copy
    pulse_set(32'h0000_0100, 32'h0);
    read_chk("R9 shared set via secure", 1'b0, BASE + 12'd1, 2'd0, 32'h0000_0001);

    // R9: set and clear on bit 9 in the same cycle, clear alone on bit 8
    @(negedge clk);
    set_ns     = 32'h0000_0200;
    req_valid  = 1'b1;
    req_write  = 1'b1;
    req_secure = 1'b0;
    req_addr   = BASE + 12'd1;
    req_size   = 2'd0;
    req_wdata  = 32'h0000_0003;
    @(negedge clk);
    set_ns    = '0;
    req_valid = 1'b0;
    req_write = 1'b0;
    read_chk("R9 set wins over clear", 1'b0, BASE + 12'd1, 2'd0, 32'h0000_0002);

    // R5: non-secure strobe outside the shared field stays in its own copy
    pulse_set(32'h0, 32'h0000_0001);
    read_chk("R5 secure unaffected", 1'b1, BASE, 2'd0, 32'h0000_000E);
    read_chk("R5 non-secure set", 1'b0, BASE, 2'd0, 32'h0000_00FF);

    // R7: secure word clear reaches the shared field in the non-secure copy
    access(1'b1, 1'b1, BASE, 2'd2, 32'h0000_0200, rd, vld);
    read_chk("R7 secure clear of shared bit", 1'b0, BASE + 12'd1, 2'd0, 32'h0000_0000);

    // R10: a write produces no response
    access(1'b1, 1'b0, BASE, 2'd2, 32'h0, rd, vld);
    check("R10 no response to write", {31'h0, vld}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule